// File: doc/BRIEF.md
# IPv4 Header Check and Update Unit

This block sits in a router datapath and watches a stream of 32-bit IPv4 header words, one word per cycle when `in_valid` is high, with `in_last` marking the final header word. It tracks the position of each word in the header. From that position it takes the version from word 0 and the time-to-live and stored checksum from word 2. It hands the destination address in word 4 to a route lookup stage with a one-cycle strobe.

While the header streams in, two ones'-complement accumulators run side by side. One sums the header exactly as received, to check the checksum. The other sums it as it will leave: the TTL is lowered by one and the checksum field is counted as zero. This gives the replacement checksum. One cycle after the last word, a single `done` pulse presents the forward-or-drop verdict, the new TTL and the new checksum together. A later stage can splice these fields into the buffered header. The unchanged header words are not stored here.

Top module: `ipv4_hdr_proc`

## Requirements
- R1: After reset, `done`, `dst_valid` and `drop` are 0.
- R2: The word accepted after a word with `in_last` high is word 0 of a new header, so headers may follow back to back with no idle cycle.
- R3: A header whose word 0 bits [31:28] (version) are not 4 is dropped.
- R4: The TTL is word 2 bits [31:24]. A TTL of 0 is dropped, because decrementing it would go below zero. `ttl_new` is TTL-1, or 0 when the TTL is 0.
- R5: The header is dropped unless the ones'-complement sum, with end-around carry, of all its 16-bit halves equals 0xFFFF.
- R6: `csum_new` is the ones'-complement of the end-around-carry sum over all header halves, with word 2 bits [31:24] replaced by `ttl_new` and word 2 bits [15:0] taken as zero.
- R7: One cycle after word 4 is accepted, `dst_valid` pulses for one cycle and `dst_addr` holds that word.
- R8: `done` is high for exactly the one cycle after a word with `in_last` is accepted. `drop`, `ttl_new` and `csum_new` change only in that cycle and hold until the next `done`.
- R9: Cycles with `in_valid` low have no effect: they neither advance the word position nor enter the sums.
- R10: A header that ends before word 4 is dropped and produces no `dst_valid`.
- R11: Option words (position 5 and above) enter both checksums and are otherwise ignored. The word position saturates at 15, so a long header decodes its fields only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header word present on `in_data` this cycle |
| in_data | input | 32 | Header word |
| in_last | input | 1 | This word is the last word of the header |
| dst_valid | output | 1 | One-cycle strobe: `dst_addr` is new |
| dst_addr | output | 32 | Destination address for the route lookup |
| done | output | 1 | One-cycle strobe: verdict and updated fields are valid |
| drop | output | 1 | 1 = discard the packet, 0 = forward it |
| ttl_new | output | 8 | Decremented TTL to substitute |
| csum_new | output | 16 | Recomputed header checksum to substitute |

## Verification
The bench targets the edges of the TTL test. A TTL of 1 must forward with a new TTL of 0, while a TTL of 0 must drop; an off-by-one comparison would swap these two cases. A header with a single flipped checksum bit must drop. Its replacement checksum must still match the one computed from the outgoing fields, which catches a design that mixes the received and outgoing sums. The bench also sends headers with idle gaps, headers back to back, a header too short to carry a destination, and headers longer than the position counter can count. A design that miscounts positions would decode the wrong word as the TTL or the destination, or would pulse `dst_valid` twice.

// File: rtl/ipv4_hdr_pkg.sv
package ipv4_hdr_pkg;

  localparam int HALF_W = 16;

  // end-around-carry addition of two 16-bit halves
  function automatic logic [HALF_W-1:0] oc_add(input logic [HALF_W-1:0] a,
                                                input logic [HALF_W-1:0] b);
    logic [HALF_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, s[HALF_W]};
  endfunction

  typedef struct packed {
    logic [7:0]  ttl;
    logic [7:0]  proto;
    logic [15:0] csum;
  } ttl_word_t;

  typedef struct packed {
    logic [3:0]  version;
    logic [3:0]  hlen;
    logic [7:0]  tos;
    logic [15:0] total_len;
  } ver_word_t;

endpackage

// File: rtl/hdr_word_index.sv
module hdr_word_index #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (in_valid) begin
      if (in_last)
        idx_d = '0;
      else if (idx_q != IDX_MAX)
        idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else
      idx_q <= idx_d;
  end

  assign idx = idx_q;

  // R9
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(idx_q));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (idx_q == '0));

endmodule

// File: rtl/hdr_csum_acc.sv
module hdr_csum_acc
  import ipv4_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [HALF_W-1:0] half_hi,
  input  logic [HALF_W-1:0] half_lo,
  output logic [HALF_W-1:0] sum_now
);
  logic [HALF_W-1:0] acc_q, acc_d;

  always_comb begin
    sum_now = oc_add(oc_add(acc_q, half_hi), half_lo);
    acc_d   = acc_q;
    if (in_valid)
      acc_d = in_last ? '0 : sum_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else
      acc_q <= acc_d;
  end

endmodule

// File: rtl/hdr_field_check.sv
module hdr_field_check
  import ipv4_hdr_pkg::*;
#(
  parameter int          IDX_W   = 4,
  parameter logic [3:0]  IP_VER  = 4'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  input  logic [IDX_W-1:0]  idx,
  output logic [HALF_W-1:0] out_hi,
  output logic [HALF_W-1:0] out_lo,
  output logic              bad_now,
  output logic [7:0]        ttl_now,
  output logic              dst_valid,
  output logic [31:0]       dst_addr
);
  localparam logic [IDX_W-1:0] POS_VER = IDX_W'(0);
  localparam logic [IDX_W-1:0] POS_TTL = IDX_W'(2);
  localparam logic [IDX_W-1:0] POS_DST = IDX_W'(4);

  ver_word_t w_ver;
  ttl_word_t w_ttl;
  assign w_ver = ver_word_t'(in_data);
  assign w_ttl = ttl_word_t'(in_data);

  logic       ver_bad_q, ttl_zero_q, reached_q;
  logic [7:0] ttl_q;
  logic       ver_bad_d, ttl_zero_d, reached_d;
  logic [7:0] ttl_d;
  logic       ver_bad_now, ttl_zero_now, reached_now;
  logic [7:0] ttl_dec;
  logic       dv_d;
  logic [31:0] da_d;
  logic       dv_q;
  logic [31:0] da_q;

  always_comb begin
    ttl_dec      = (w_ttl.ttl == 8'd0) ? 8'd0 : w_ttl.ttl - 8'd1;
    ver_bad_now  = (idx == POS_VER) ? (w_ver.version != IP_VER) : ver_bad_q;
    ttl_zero_now = (idx == POS_TTL) ? (w_ttl.ttl == 8'd0) : ttl_zero_q;
    ttl_now      = (idx == POS_TTL) ? ttl_dec : ttl_q;
    reached_now  = (idx == POS_DST) ? 1'b1 :
                   (idx == POS_VER) ? 1'b0 : reached_q;
    bad_now      = ver_bad_now | ttl_zero_now | ~reached_now;

    // halves as they will leave the block
    if (idx == POS_TTL) begin
      out_hi = {ttl_dec, w_ttl.proto};
      out_lo = '0;
    end else begin
      out_hi = in_data[31:16];
      out_lo = in_data[15:0];
    end

    ver_bad_d  = ver_bad_q;
    ttl_zero_d = ttl_zero_q;
    ttl_d      = ttl_q;
    reached_d  = reached_q;
    dv_d       = 1'b0;
    da_d       = da_q;
    if (in_valid) begin
      ver_bad_d  = ver_bad_now;
      ttl_zero_d = ttl_zero_now;
      ttl_d      = ttl_now;
      reached_d  = reached_now;
      if (idx == POS_DST) begin
        dv_d = 1'b1;
        da_d = in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ver_bad_q  <= 1'b0;
      ttl_zero_q <= 1'b0;
      ttl_q      <= '0;
      reached_q  <= 1'b0;
      dv_q       <= 1'b0;
      da_q       <= '0;
    end else begin
      ver_bad_q  <= ver_bad_d;
      ttl_zero_q <= ttl_zero_d;
      ttl_q      <= ttl_d;
      reached_q  <= reached_d;
      dv_q       <= dv_d;
      da_q       <= da_d;
    end
  end

  assign dst_valid = dv_q;
  assign dst_addr  = da_q;

  // R7
  dst_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> $past(in_valid));

endmodule

// File: rtl/ipv4_hdr_proc.sv
module ipv4_hdr_proc
  import ipv4_hdr_pkg::*;
#(
  parameter int         IDX_W  = 4,
  parameter logic [3:0] IP_VER = 4'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        dst_valid,
  output logic [31:0] dst_addr,
  output logic        done,
  output logic        drop,
  output logic [7:0]  ttl_new,
  output logic [15:0] csum_new
);
  localparam logic [HALF_W-1:0] SUM_OK = {HALF_W{1'b1}};

  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] out_hi, out_lo;
  logic [HALF_W-1:0] rx_sum, tx_sum;
  logic              bad_now;
  logic [7:0]        ttl_now;

  hdr_word_index #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .idx(idx)
  );

  hdr_field_check #(.IDX_W(IDX_W), .IP_VER(IP_VER)) u_fld (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .idx(idx),
    .out_hi(out_hi), .out_lo(out_lo), .bad_now(bad_now), .ttl_now(ttl_now),
    .dst_valid(dst_valid), .dst_addr(dst_addr)
  );

  hdr_csum_acc u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .half_hi(in_data[31:16]), .half_lo(in_data[15:0]), .sum_now(rx_sum)
  );

  hdr_csum_acc u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .half_hi(out_hi), .half_lo(out_lo), .sum_now(tx_sum)
  );

  logic        done_q, drop_q;
  logic [7:0]  ttl_q;
  logic [15:0] csum_q;
  logic        fin_en;
  logic        drop_d;
  logic [15:0] csum_d;

  always_comb begin
    fin_en = in_valid & in_last;
    drop_d = bad_now | (rx_sum != SUM_OK);
    csum_d = ~tx_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      drop_q <= 1'b0;
      ttl_q  <= '0;
      csum_q <= '0;
    end else begin
      done_q <= fin_en;
      if (fin_en) begin
        drop_q <= drop_d;
        ttl_q  <= ttl_now;
        csum_q <= csum_d;
      end
    end
  end

  assign done     = done_q;
  assign drop     = drop_q;
  assign ttl_new  = ttl_q;
  assign csum_new = csum_q;

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));

  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop) |-> done);

  // R8
  csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(csum_new));

endmodule

// File: tb/sim_ipv4_hdr_proc.sv
module sim_ipv4_hdr_proc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        dst_valid, done, drop;
  logic [31:0] dst_addr;
  logic [7:0]  ttl_new;
  logic [15:0] csum_new;

  int errors = 0;
  int checks = 0;

  logic [31:0] hw [0:19];
  int          hn;
  int          seen_dst, seen_done, done_ok;
  logic [31:0] got_dst;

  always #2.5 clk = ~clk;

  ipv4_hdr_proc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .done(done), .drop(drop), .ttl_new(ttl_new), .csum_new(csum_new)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sum(input bit outgoing);
    int unsigned t = 0;
    for (int i = 0; i < hn; i++) begin
      logic [31:0] w = hw[i];
      if (outgoing && i == 2)
        w = {(w[31:24] == 0 ? 8'd0 : w[31:24] - 8'd1), w[23:16], 16'h0};
      t += w[31:16];
      t += w[15:0];
    end
    while (t > 32'hFFFF) t = (t & 32'hFFFF) + (t >> 16);
    return t[15:0];
  endfunction

  task automatic make_hdr(input logic [3:0] ver, input logic [7:0] ttl,
                          input int nw, input logic [31:0] dst);
    hn = nw;
    for (int i = 0; i < 20; i++) hw[i] = 32'h5A5A0000 + 32'(i * 7);
    hw[0] = {ver, 4'(nw), 8'h00, 16'(nw * 4 + 200)};
    hw[1] = {16'(nw + 16'h2100), 16'h4000};
    hw[2] = {ttl, 8'h06, 16'h0000};
    hw[3] = 32'hC0A80101;
    hw[4] = dst;
    if (nw > 2) hw[2][15:0] = ~ref_sum(1'b0);
  endtask

  // drive the header; done is sampled one cycle after the last word
  task automatic send(input bit gaps);
    seen_dst = 0; seen_done = 0; done_ok = 0;
    for (int i = 0; i < hn; i++) begin
      in_valid = 1'b1; in_data = hw[i]; in_last = (i == hn - 1);
      @(negedge clk);
      if (dst_valid) begin seen_dst++; got_dst = dst_addr; end
      if (done) begin seen_done++; if (i == hn - 1) done_ok = 1; end
      if (gaps) begin
        in_valid = 1'b0; in_data = 32'hFFFFFFFF; in_last = 1'b1;
        @(negedge clk);
        if (dst_valid) seen_dst++;
        if (done) seen_done++;
      end
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic verdict(input string req, input bit exp_drop,
                         input logic [7:0] exp_ttl, input bit exp_dst);
    logic [15:0] exp_cs = ~ref_sum(1'b1);
    chk(done_ok == 1 && seen_done == 1, {req, " done pulse"}, seen_done, 1);
    chk(drop == exp_drop, {req, " drop"}, drop, exp_drop);
    chk(ttl_new == exp_ttl, {req, " ttl_new"}, ttl_new, exp_ttl);
    chk(csum_new == exp_cs, {"R6 ", req, " csum_new"}, csum_new, exp_cs);
    if (exp_dst) begin
      chk(seen_dst == 1, {"R7 ", req, " dst strobes"}, seen_dst, 1);
      chk(got_dst == hw[4], {"R7 ", req, " dst_addr"}, got_dst, hw[4]);
    end
  endtask

  task automatic t_good();
    make_hdr(4'd4, 8'd64, 5, 32'h08080808); send(1'b0); idle(1);
    verdict("R5 good", 1'b0, 8'd63, 1'b1);
  endtask

  task automatic t_version();
    make_hdr(4'd6, 8'd64, 5, 32'h01020304); send(1'b0); idle(1);
    verdict("R3 version6", 1'b1, 8'd63, 1'b1);
  endtask

  task automatic t_ttl_edges();
    make_hdr(4'd4, 8'd0, 5, 32'h0A0B0C0D); send(1'b0); idle(1);
    verdict("R4 ttl0", 1'b1, 8'd0, 1'b1);
    make_hdr(4'd4, 8'd1, 5, 32'h0A0B0C0E); send(1'b0); idle(1);
    verdict("R4 ttl1", 1'b0, 8'd0, 1'b1);
  endtask

  task automatic t_bad_csum();
    make_hdr(4'd4, 8'd20, 5, 32'hAC100001);
    hw[2][3] = ~hw[2][3];
    send(1'b0); idle(1);
    verdict("R5 corrupt", 1'b1, 8'd19, 1'b1);
  endtask

  task automatic t_gaps();
    make_hdr(4'd4, 8'd128, 5, 32'hDEADBEEF); send(1'b1); idle(1);
    verdict("R9 gaps", 1'b0, 8'd127, 1'b1);
    chk(seen_done == 1, "R9 no extra done in gaps", seen_done, 1);
  endtask

  task automatic t_options();
    make_hdr(4'd4, 8'd9, 8, 32'h11223344); send(1'b0); idle(1);
    verdict("R11 options", 1'b0, 8'd8, 1'b1);
  endtask

  task automatic t_short();
    make_hdr(4'd4, 8'd9, 3, 32'h0); send(1'b0); idle(1);
    verdict("R10 short", 1'b1, 8'd8, 1'b0);
    chk(seen_dst == 0, "R10 no dst_valid", seen_dst, 0);
  endtask

  task automatic t_back_to_back();
    make_hdr(4'd5, 8'd30, 5, 32'h99990000); send(1'b0);
    chk(done_ok == 1 && drop == 1'b1, "R2 first of pair dropped", drop, 1);
    make_hdr(4'd4, 8'd31, 6, 32'h77776666); send(1'b0); idle(1);
    verdict("R2 second of pair", 1'b0, 8'd30, 1'b1);
  endtask

  task automatic t_long();
    make_hdr(4'd4, 8'd2, 18, 32'h55AA55AA); send(1'b0); idle(1);
    verdict("R11 saturate", 1'b0, 8'd1, 1'b1);
  endtask

  task automatic t_hold();
    logic [15:0] cs0 = csum_new;
    logic        d0  = drop;
    int          hi  = 0;
    in_valid = 1'b0; in_last = 1'b1; in_data = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done || dst_valid) hi++;
    end
    chk(hi == 0, "R8 no strobe while idle", hi, 0);
    chk(csum_new == cs0 && drop == d0, "R8 outputs held", {drop, 15'd0, csum_new},
        {d0, 15'd0, cs0});
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && dst_valid == 0 && drop == 0, "R1 reset state",
        {done, dst_valid, drop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && drop == 0, "R1 after release", {done, drop}, 0);
    t_good();
    t_version();
    t_ttl_edges();
    t_bad_csum();
    t_hold();
    t_gaps();
    t_options();
    t_short();
    t_back_to_back();
    t_long();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule